// File: doc/BRIEF.md
# Inter-Record Gap Delay Timer

This block measures the gap a tape transport needs to reach speed before a record, or to come to rest after one. It counts motion pulses, one per character time of the selected transport. The pulses arrive as single-cycle clock enables on the system clock. Near the end of the first 32-pulse period, the block asks the transport for its start-stop characteristic: a delay-sync flag is raised, and on the next pulse a strobe copies the 8-bit delay value into a timing register. From the following pulse on, the timing register is decremented once every 32 motion pulses. When it runs out, the block emits a single-cycle delay-over pulse.

A level `enable` starts a delay. The block disarms itself when delay-over is produced and stays quiet until `enable` is dropped and raised again. Dropping `enable` abandons a delay without a delay-over pulse. The same sequence times both the acceleration gap and the deceleration gap. All outputs are registered and change in the cycle after the motion pulse that causes them. Counting pulses from the rising edge of `enable`, delay-over follows motion pulse number 32·V, where V is the captured delay value, and a captured 0 counts as 1.

Top module: `irg_delay_timer`

## Requirements
- R1: After reset all four outputs are 0.
- R2: In the cycle after the 30th motion pulse since `enable` rose, `sync_o` goes to 1 while `xfer_o` is 0. It stays at 1 until the strobe.
- R3: The 31st motion pulse sets `strobe_o` for exactly one cycle, clears `sync_o` and sets `xfer_o`, all in the same following cycle.
- R4: `delay_val` is sampled only at the 31st motion pulse. Its value at any other time has no effect, and a sampled 0 behaves as 1.
- R5: Decrements occur at motion pulse 32 and at every 32nd pulse after it. `delay_over_o` is 1 in the cycle after motion pulse 32·V.
- R6: `delay_over_o` lasts one cycle and clears `xfer_o`. Afterwards, while `enable` stays 1, further motion pulses produce no output activity.
- R7: After `xfer_o` is set, the 30th and 31st pulses of later 32-pulse periods raise neither `sync_o` nor `strobe_o`.
- R8: With `enable` at 0 on a clock edge, all outputs are 0 in the following cycle and no `delay_over_o` is produced, even if a motion pulse arrives on that edge. Raising `enable` again starts a fresh count.
- R9: Cycles without a motion pulse advance nothing. `strobe_o` and `delay_over_o` stay 0, and `sync_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Level that arms a delay; 0 clears the block |
| motion_pulse | input | 1 | One-cycle pulse per transport character time |
| delay_val | input | 8 | Start-stop characteristic from the transport |
| sync_o | output | 1 | Delay-sync flag: value fetch requested |
| strobe_o | output | 1 | One-cycle strobe: value captured |
| xfer_o | output | 1 | Delay value transferred, countdown running |
| delay_over_o | output | 1 | One-cycle end-of-delay pulse |

## Verification
Two events can fall on the same clock edge: the last decrement that would end the delay, and the clear caused by `enable` dropping. The bench runs a dense count to pulse 32·V−1. It then applies the final motion pulse on the same edge where `enable` goes low, and expects every output to be 0 with no delay-over pulse. A second coincidence occurs when the value strobe overlaps random changes on `delay_val`. This is judged by checking that the delay-over pulse lands exactly at 32 times the value present at pulse 31.

// File: rtl/irg_pkg.sv
package irg_pkg;
    // Per-cycle decode of the motion counter position
    typedef struct packed {
        logic tick;        // qualified motion pulse
        logic sync_hit;    // pulse completing the sync position
        logic strobe_hit;  // pulse completing the strobe position
        logic down_hit;    // pulse closing a 32-pulse period
    } irg_evt_t;
endpackage

// File: rtl/irg_motion_seq.sv
module irg_motion_seq
    import irg_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int SYNC_AT = 30
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  logic     motion_pulse,
    input  logic     expire,
    output irg_evt_t evt
);
    localparam int PERIOD = 2 ** CNT_W;
    localparam logic [CNT_W-1:0] SYNC_POS   = CNT_W'(SYNC_AT - 1);
    localparam logic [CNT_W-1:0] STROBE_POS = CNT_W'(SYNC_AT);
    localparam logic [CNT_W-1:0] DOWN_POS   = CNT_W'(PERIOD - 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             done;
    } seq_st_t;

    seq_st_t st_d, st_q;

    always_comb begin
        logic run;
        run              = enable && !st_q.done;
        evt.tick         = motion_pulse && run;
        evt.sync_hit     = evt.tick && (st_q.cnt == SYNC_POS);
        evt.strobe_hit   = evt.tick && (st_q.cnt == STROBE_POS);
        evt.down_hit     = evt.tick && (st_q.cnt == DOWN_POS);

        st_d = st_q;
        if (!enable) begin
            st_d.cnt  = '0;
            st_d.done = 1'b0;
        end else begin
            if (evt.tick) st_d.cnt = st_q.cnt + 1'b1;
            if (expire)   st_d.done = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irg_fetch_ctl.sv
module irg_fetch_ctl
    import irg_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     enable,
    input  irg_evt_t evt,
    input  logic     expire,
    output logic     load,
    output logic     down_en,
    output logic     sync_q_o,
    output logic     strobe_q_o,
    output logic     xfer_q_o
);
    typedef struct packed {
        logic sync;
        logic strobe;
        logic xfer;
    } fetch_st_t;

    fetch_st_t st_d, st_q;

    always_comb begin
        load    = evt.strobe_hit && st_q.sync;
        down_en = evt.down_hit && st_q.xfer;

        st_d        = st_q;
        st_d.strobe = load;
        if (!enable) begin
            st_d = '0;
        end else begin
            if (evt.sync_hit && !st_q.xfer) st_d.sync = 1'b1;
            if (load) begin
                st_d.sync = 1'b0;
                st_d.xfer = 1'b1;
            end
            if (expire) st_d.xfer = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_q_o   = st_q.sync;
    assign strobe_q_o = st_q.strobe;
    assign xfer_q_o   = st_q.xfer;
endmodule

// File: rtl/irg_down_timer.sv
module irg_down_timer #(
    parameter int T_W = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           load,
    input  logic [T_W-1:0] load_val,
    input  logic           down_en,
    output logic           expire,
    output logic           over_q_o
);
    localparam logic [T_W-1:0] ONE = T_W'(1);

    typedef struct packed {
        logic [T_W-1:0] tmr;
        logic           over;
    } tmr_st_t;

    tmr_st_t st_d, st_q;

    always_comb begin
        expire = down_en && (st_q.tmr <= ONE);

        st_d      = st_q;
        st_d.over = expire;
        if (!enable) begin
            st_d = '0;
        end else if (load) begin
            st_d.tmr = (load_val == '0) ? ONE : load_val;
        end else if (expire) begin
            st_d.tmr = '0;
        end else if (down_en) begin
            st_d.tmr = st_q.tmr - ONE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign over_q_o = st_q.over;
endmodule

// File: rtl/irg_delay_timer.sv
module irg_delay_timer
    import irg_pkg::*;
#(
    parameter int CNT_W   = 5,
    parameter int T_W     = 8,
    parameter int SYNC_AT = 30
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           motion_pulse,
    input  logic [T_W-1:0] delay_val,
    output logic           sync_o,
    output logic           strobe_o,
    output logic           xfer_o,
    output logic           delay_over_o
);
    irg_evt_t evt;
    logic     expire;
    logic     load;
    logic     down_en;

    irg_motion_seq #(.CNT_W(CNT_W), .SYNC_AT(SYNC_AT)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .motion_pulse (motion_pulse),
        .expire       (expire),
        .evt          (evt)
    );

    irg_fetch_ctl u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable     (enable),
        .evt        (evt),
        .expire     (expire),
        .load       (load),
        .down_en    (down_en),
        .sync_q_o   (sync_o),
        .strobe_q_o (strobe_o),
        .xfer_q_o   (xfer_o)
    );

    irg_down_timer #(.T_W(T_W)) u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable),
        .load     (load),
        .load_val (delay_val),
        .down_en  (down_en),
        .expire   (expire),
        .over_q_o (delay_over_o)
    );
endmodule

// File: rtl/irg_delay_timer_chk.sv
module irg_delay_timer_chk (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic motion_pulse,
    input logic sync_o,
    input logic strobe_o,
    input logic xfer_o,
    input logic delay_over_o
);
    assert_sync_only_pre_xfer_R2: assert property (@(posedge clk) disable iff (!rst_n)
        sync_o |-> !xfer_o);

    assert_strobe_sets_xfer_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> (xfer_o && !sync_o));

    assert_strobe_follows_sync_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |-> $past(sync_o));

    assert_strobe_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_o |=> !strobe_o);

    assert_over_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        delay_over_o |=> !delay_over_o);

    assert_over_clears_xfer_R6: assert property (@(posedge clk) disable iff (!rst_n)
        delay_over_o |-> (!xfer_o && $past(xfer_o)));

    assert_disable_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sync_o && !strobe_o && !xfer_o && !delay_over_o));

    assert_idle_no_event_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && !motion_pulse) |=> (!strobe_o && !delay_over_o && $stable(sync_o)));
endmodule

bind irg_delay_timer irg_delay_timer_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .enable       (enable),
    .motion_pulse (motion_pulse),
    .sync_o       (sync_o),
    .strobe_o     (strobe_o),
    .xfer_o       (xfer_o),
    .delay_over_o (delay_over_o)
);

// File: tb/irg_delay_timer_test.sv
module irg_delay_timer_test;
    localparam int CLK_PERIOD = 10;
    localparam int WDOG_CYC   = 190000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       motion_pulse = 1'b0;
    logic [7:0] delay_val = 8'd0;
    logic       sync_o, strobe_o, xfer_o, delay_over_o;

    int vectors = 0;
    int fails = 0;
    string phase = "R1";

    // bench model state
    int  m_n = 0;
    int  m_v = 0;
    bit  m_done = 0;
    bit  m_lastp = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    irg_delay_timer uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .motion_pulse(motion_pulse),
        .delay_val(delay_val), .sync_o(sync_o), .strobe_o(strobe_o),
        .xfer_o(xfer_o), .delay_over_o(delay_over_o)
    );

    function automatic bit exp_sync(int n);
        return n == 30;
    endfunction
    function automatic bit exp_strobe(int n, bit lastp);
        return lastp && n == 31;
    endfunction
    function automatic bit exp_xfer(int n, bit done);
        return n >= 31 && !done;
    endfunction
    function automatic bit exp_over(int n, int v, bit lastp, bit done);
        return lastp && done && n == 32 * v;
    endfunction

    task automatic cmp(string what, string tag, logic act, bit exp);
        if (act !== exp) begin
            fails++;
            $display("FAIL %s [%s, phase %s] n=%0d: actual=%b expected=%b",
                     what, tag, phase, m_n, act, exp);
        end
    endtask

    task automatic check_all();
        vectors++;
        cmp("sync_o", (m_n > 31) ? "R7" : "R2", sync_o, exp_sync(m_n));
        cmp("strobe_o", (m_n > 31) ? "R7" : "R3", strobe_o, exp_strobe(m_n, m_lastp));
        cmp("xfer_o", m_done ? "R6" : "R3", xfer_o, exp_xfer(m_n, m_done));
        cmp("delay_over_o", "R5", delay_over_o, exp_over(m_n, m_v, m_lastp, m_done));
    endtask

    // Called at a negedge: apply inputs, advance model over the edge, check.
    task automatic step(bit en, bit p, logic [7:0] val);
        enable = en;
        motion_pulse = p;
        delay_val = val;
        @(posedge clk);
        if (!en) begin
            m_n = 0; m_done = 0; m_v = 0; m_lastp = 0;
        end else if (p && !m_done) begin
            m_n++;
            m_lastp = 1;
            if (m_n == 31) m_v = (val == 8'd0) ? 1 : int'(val);
            if (m_n >= 31 && m_n == 32 * m_v) m_done = 1;
        end else begin
            m_lastp = 0;
        end
        @(negedge clk);
        check_all();
    endtask

    task automatic dense_run(logic [7:0] v, bit scramble);
        int guard = 0;
        while (!m_done && guard < 9000) begin
            logic [7:0] val;
            val = (scramble && m_n != 30) ? 8'($urandom_range(0, 255)) : v;
            step(1, 1, val);
            guard++;
        end
    endtask

    task automatic disarm();
        step(0, 0, 8'd0);
        step(0, 0, 8'd0);
    endtask

    initial begin
        repeat (WDOG_CYC) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        phase = "R1";
        check_all();

        // R2 R3 R5: dense run, value 3
        phase = "R5";
        dense_run(8'd3, 1'b0);
        // R6: stays quiet after delay-over while enabled
        phase = "R6";
        for (int i = 0; i < 70; i++) step(1, 1, 8'd9);
        disarm();

        // R4: value scrambled except at the strobe pulse
        phase = "R4";
        dense_run(8'd2, 1'b1);
        disarm();
        // R4: captured zero acts as one
        dense_run(8'd0, 1'b0);
        disarm();

        // R8: abandon mid-count, then fresh count
        phase = "R8";
        for (int i = 0; i < 50; i++) step(1, 1, 8'd4);
        step(0, 1, 8'd4);
        dense_run(8'd1, 1'b0);
        disarm();
        // R8: disable on the edge of the final pulse
        for (int i = 0; i < 63; i++) step(1, 1, 8'd2);
        step(0, 1, 8'd2);
        vectors++;
        if (delay_over_o !== 1'b0) begin
            fails++;
            $display("FAIL delay_over_o R8 coincident clear: actual=%b expected=0", delay_over_o);
        end
        disarm();

        // R9: sparse pulses, random gaps
        phase = "R9";
        for (int r = 0; r < 24; r++) begin
            int prob = $urandom_range(20, 100);
            int guard = 0;
            logic [7:0] v = 8'($urandom_range(0, 4));
            while (!m_done && guard < 2000) begin
                bit en = ($urandom_range(0, 399) != 0);
                step(en, ($urandom_range(0, 99) < prob), (m_n == 30) ? v : 8'($urandom_range(0, 255)));
                guard++;
            end
            for (int i = 0; i < 5; i++) step(1, $urandom_range(0, 1) == 1, 8'd7);
            disarm();
        end

        // R5: largest value
        phase = "R5";
        dense_run(8'd255, 1'b0);
        disarm();

        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule